// File: doc/BRIEF.md
# Invertible-Operand Arithmetic/Logic Unit with Flags

This block is a purely combinational N-bit arithmetic/logic unit with a default width of 16 bits. Each operand can be bitwise complemented before it reaches the function units. A two-bit function select picks one of three native functions: bitwise AND, bitwise OR, or addition of the two conditioned operands plus a separate carry-in bit. The fourth code returns zero.

Subtraction, NOR and NAND are not native functions. They come from combining the inversion controls with the carry-in:

- Complementing B and setting carry-in, with addition selected, gives A minus B.
- Complementing A and setting carry-in, with addition selected, gives B minus A.
- Complementing both operands gives NOR under the AND code and NAND under the OR code.

The carry-out and signed-overflow flags always describe the adder, whichever function drives the result. The sign and zero flags always describe the selected result. The block has no clock and no state. It is meant to sit between a register file's read ports and its write port.

Top module: `alu_invop`

## Requirements
- R1: Function code 2'b00 drives the result with the bitwise AND of the two conditioned operands.
- R2: Function code 2'b01 drives the result with the bitwise OR of the two conditioned operands.
- R3: Function code 2'b10 drives the result with the low N bits of the sum of the two conditioned operands and carry_in.
- R4: Function code 2'b11 drives an all-zero result. The four flags keep their usual definitions.
- R5: When inv_a is 1, operand A is replaced by its bitwise complement before any function. When inv_b is 1, the same applies to B. When a control is 0, its operand passes unchanged.
- R6: With inv_b=1, carry_in=1 and inv_a=0 under function code 2'b10, the result is A minus B modulo 2^N.
- R7: With inv_a=1 and inv_b=1, function code 2'b00 gives NOR of A and B, and function code 2'b01 gives NAND of A and B.
- R8: With inv_a=1, carry_in=1 and inv_b=0 under function code 2'b10, the result is B minus A modulo 2^N.
- R9: carry_out is bit N of the unsigned sum of the conditioned operands plus carry_in, for every function code.
- R10: overflow is 1 exactly when the two's-complement sum of the conditioned operands plus carry_in lies outside the signed N-bit range. This holds for every function code.
- R11: sign equals the most significant bit of the selected result.
- R12: zero is 1 exactly when every bit of the selected result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | N | Operand A |
| opb | input | N | Operand B |
| inv_a | input | 1 | Complement operand A before use |
| inv_b | input | 1 | Complement operand B before use |
| carry_in | input | 1 | Carry into the adder's least significant bit |
| fn_sel | input | 2 | Function code: 00 AND, 01 OR, 10 add, 11 zero |
| result | output | N | Selected function output |
| carry_out | output | 1 | Carry out of the adder's most significant bit |
| sign | output | 1 | Most significant bit of result |
| overflow | output | 1 | Signed overflow of the adder |
| zero | output | 1 | Result is all zeros |

## Verification
Uniformly random operands are applied with every combination of the inversion controls, the carry-in and the four function codes. These vectors show whether each function, each operand conditioning path and each flag is wired to the right source. Random data alone rarely reaches the extremes, so directed vectors add sums that cross the signed limits in both directions, zero and all-ones operands, and operands equal to each other. These separate a carry-out fault from an overflow fault and catch an inverted zero flag.

Further directed cases derive subtraction, reverse subtraction, NOR and NAND from the control settings. They compare those results with arithmetic written directly on the raw operands. This shows whether the carry-in and inversion work together as intended.

// File: rtl/alu_invop_pkg.sv
package alu_invop_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_ADD  = 2'b10,
    FN_NONE = 2'b11
  } fn_e;

  // one-bit full adder: {carry, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    return {co, s};
  endfunction

  // signed overflow from the carries around the top bit
  function automatic logic ovf_from_carries(input logic c_into_msb, input logic c_out_msb);
    return c_into_msb ^ c_out_msb;
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         invert,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ invert;
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
  import alu_invop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic [1:0] fa;
    assign fa         = full_add(x[i], y[i], carry[i]);
    assign sum[i]     = fa[0];
    assign carry[i+1] = fa[1];
  end

  assign c_into_msb = carry[W-1];
  assign c_out      = carry[W];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_invop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  input  logic         c_into_msb,
  input  logic         c_out,
  output logic         carry_flag,
  output logic         sign_flag,
  output logic         ovf_flag,
  output logic         zero_flag
);
  assign carry_flag = c_out;
  assign ovf_flag   = ovf_from_carries(c_into_msb, c_out);
  assign sign_flag  = res[W-1];
  assign zero_flag  = ~|res;
endmodule

// File: rtl/alu_invop.sv
module alu_invop
  import alu_invop_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         carry_in,
  input  logic [1:0]   fn_sel,
  output logic [N-1:0] result,
  output logic         carry_out,
  output logic         sign,
  output logic         overflow,
  output logic         zero
);
  localparam int MSB = N - 1;

  logic [N-1:0] cond_a, cond_b, sum, and_v, or_v;
  logic         c_msb_in, c_msb_out;
  logic [2:0]   fn_onehot;   // {add, or, and}

  alu_operand_cond #(.W(N)) u_cond_a (.din(opa), .invert(inv_a), .dout(cond_a));
  alu_operand_cond #(.W(N)) u_cond_b (.din(opb), .invert(inv_b), .dout(cond_b));

  alu_ripple_adder #(.W(N)) u_add (
    .x(cond_a), .y(cond_b), .cin(carry_in),
    .sum(sum), .c_into_msb(c_msb_in), .c_out(c_msb_out)
  );

  assign and_v = cond_a & cond_b;
  assign or_v  = cond_a | cond_b;

  always_comb begin
    fn_onehot = 3'b000;
    case (fn_e'(fn_sel))
      FN_AND:  fn_onehot = 3'b001;
      FN_OR:   fn_onehot = 3'b010;
      FN_ADD:  fn_onehot = 3'b100;
      default: fn_onehot = 3'b000;
    endcase
  end

  always_comb begin
    result = '0;
    for (int i = 0; i <= MSB; i++) begin
      result[i] = (fn_onehot[0] & and_v[i]) |
                  (fn_onehot[1] & or_v[i])  |
                  (fn_onehot[2] & sum[i]);
    end
  end

  alu_flag_unit #(.W(N)) u_flags (
    .res(result), .c_into_msb(c_msb_in), .c_out(c_msb_out),
    .carry_flag(carry_out), .sign_flag(sign), .ovf_flag(overflow), .zero_flag(zero)
  );
endmodule

// File: rtl/alu_invop_chk.sv
module alu_invop_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] opa,
  input logic [N-1:0] opb,
  input logic         inv_a,
  input logic         inv_b,
  input logic         carry_in,
  input logic [1:0]   fn_sel,
  input logic [N-1:0] cond_a,
  input logic [N-1:0] cond_b,
  input logic [2:0]   fn_onehot,
  input logic [N-1:0] result,
  input logic         carry_out,
  input logic         sign,
  input logic         overflow,
  input logic         zero
);
  logic [N:0] wide;
  assign wide = {1'b0, cond_a} + {1'b0, cond_b} + {{N{1'b0}}, carry_in};

  always_comb begin
    a_r4_one_function: assert ($onehot0(fn_onehot)) else $error("function decode not one-hot");
    if (fn_sel == 2'b11)
      a_r4_idle_zero: assert (result == '0) else $error("code 11 result not zero");
    a_r5_cond_a: assert ((cond_a ^ opa) == {N{inv_a}}) else $error("A conditioning wrong");
    a_r9_carry_out: assert (carry_out == wide[N]) else $error("carry_out mismatch");
    a_r10_overflow: assert (overflow ==
      ((cond_a[N-1] == cond_b[N-1]) && (wide[N-1] != cond_a[N-1]))) else $error("overflow mismatch");
    a_r12_zero: assert (zero == ($countones(result) == 0)) else $error("zero flag mismatch");
    if (inv_a && inv_b && fn_sel == 2'b00)
      a_r7_nor: assert (result == ~(opa | opb)) else $error("NOR mismatch");
  end
endmodule

bind alu_invop alu_invop_chk #(.N(N)) i_chk (
  .opa(opa), .opb(opb), .inv_a(inv_a), .inv_b(inv_b), .carry_in(carry_in),
  .fn_sel(fn_sel), .cond_a(cond_a), .cond_b(cond_b), .fn_onehot(fn_onehot),
  .result(result), .carry_out(carry_out), .sign(sign), .overflow(overflow), .zero(zero)
);

// File: tb/test_alu_invop.sv
module test_alu_invop;
  localparam int N = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] opa, opb, result;
  logic inv_a, inv_b, carry_in, carry_out, sign, overflow, zero;
  logic [1:0] fn_sel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  alu_invop #(.N(N)) i_alu_invop (
    .opa(opa), .opb(opb), .inv_a(inv_a), .inv_b(inv_b), .carry_in(carry_in),
    .fn_sel(fn_sel), .result(result), .carry_out(carry_out), .sign(sign),
    .overflow(overflow), .zero(zero)
  );

  task automatic cmp(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h ia=%0d ib=%0d ci=%0d fn=%0d)",
               req, act, exp, opa, opb, inv_a, inv_b, carry_in, fn_sel);
    end
  endtask

  // Apply at a rising edge, check at the following falling edge.
  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic ia, input logic ib, input logic ci, input logic [1:0] f);
    @(posedge clk);
    opa = a; opb = b; inv_a = ia; inv_b = ib; carry_in = ci; fn_sel = f;
    @(negedge clk);
  endtask

  // Reference model: integer arithmetic on the conditioned operands.
  task automatic check_ref();
    longint ua, ub, usum, sa, sb, ssum;
    logic [N-1:0] ca, cb, er;
    ca = inv_a ? ~opa : opa;
    cb = inv_b ? ~opb : opb;
    ua = longint'(ca); ub = longint'(cb);
    usum = ua + ub + longint'(carry_in);
    sa = ca[N-1] ? ua - (longint'(1) << N) : ua;
    sb = cb[N-1] ? ub - (longint'(1) << N) : ub;
    ssum = sa + sb + longint'(carry_in);
    case (fn_sel)
      2'b00: begin er = ca & cb; cmp("R1", result, er); end
      2'b01: begin er = ca | cb; cmp("R2", result, er); end
      2'b10: begin er = usum[N-1:0]; cmp("R3", result, er); end
      default: begin er = '0; cmp("R4", result, er); end
    endcase
    cmp("R9",  N'(carry_out), N'(usum[N]));
    cmp("R10", N'(overflow),  N'((ssum > ((longint'(1) << (N-1)) - 1)) ||
                                 (ssum < -(longint'(1) << (N-1)))));
    cmp("R11", N'(sign), N'(er[N-1]));
    cmp("R12", N'(zero), N'(er == '0));
  endtask

  initial begin
    opa = '0; opb = '0; inv_a = 0; inv_b = 0; carry_in = 0; fn_sel = 2'b00;
    void'($urandom(32'd1789));
    @(negedge clk);
    // idle inputs: AND of zeros gives a zero result with the zero flag set
    cmp("R12", N'(zero), N'(1'b1));
    cmp("R1", result, '0);

    // exhaustive control space with random data
    for (int rep = 0; rep < 40; rep++) begin
      for (int c = 0; c < 32; c++) begin
        apply(N'($urandom), N'($urandom), c[4], c[3], c[2], c[1:0]);
        check_ref();
      end
    end

    // R5: inversion of A alone under AND yields ~A & B
    apply(16'h0FF0, 16'h3C3C, 1, 0, 0, 2'b00);
    cmp("R5", result, ~16'h0FF0 & 16'h3C3C); check_ref();
    apply(16'h0FF0, 16'h3C3C, 0, 1, 0, 2'b01);
    cmp("R5", result, 16'h0FF0 | ~16'h3C3C); check_ref();
    // R6: subtraction
    apply(16'h5EA1, 16'hF00D, 0, 1, 1, 2'b10);
    cmp("R6", result, 16'h5EA1 - 16'hF00D); check_ref();
    apply(16'h1234, 16'h1234, 0, 1, 1, 2'b10);
    cmp("R6", result, 16'h0000); cmp("R12", N'(zero), N'(1'b1)); cmp("R9", N'(carry_out), N'(1'b1));
    apply(16'h0003, 16'h0004, 0, 1, 1, 2'b10);
    cmp("R6", result, 16'hFFFF); cmp("R11", N'(sign), N'(1'b1)); check_ref();
    // R7: NOR and NAND via De Morgan
    apply(16'h6666, 16'h9999, 1, 1, 0, 2'b00);
    cmp("R7", result, ~(16'h6666 | 16'h9999)); check_ref();
    apply(16'hF0F0, 16'hFF00, 1, 1, 0, 2'b01);
    cmp("R7", result, ~(16'hF0F0 & 16'hFF00)); check_ref();
    // R8: reverse subtraction
    apply(16'h0010, 16'h0003, 1, 0, 1, 2'b10);
    cmp("R8", result, 16'h0003 - 16'h0010); check_ref();
    // R10: positive and negative overflow boundaries
    apply(16'h7FFF, 16'h0001, 0, 0, 0, 2'b10);
    cmp("R10", N'(overflow), N'(1'b1)); check_ref();
    apply(16'h8000, 16'hFFFF, 0, 0, 0, 2'b10);
    cmp("R10", N'(overflow), N'(1'b1)); cmp("R9", N'(carry_out), N'(1'b1)); check_ref();
    apply(16'h7FFE, 16'h0000, 0, 0, 1, 2'b10);
    cmp("R10", N'(overflow), N'(1'b0)); check_ref();
    // R9/R10 flags still from adder under a logic function and code 11
    apply(16'hFFFF, 16'h0001, 0, 0, 0, 2'b00);
    cmp("R9", N'(carry_out), N'(1'b1)); check_ref();
    apply(16'h7FFF, 16'h7FFF, 0, 0, 0, 2'b11);
    cmp("R4", result, '0); cmp("R10", N'(overflow), N'(1'b1)); cmp("R12", N'(zero), N'(1'b1));
    // R3: all-ones plus carry-in wraps to zero
    apply(16'hFFFF, 16'h0000, 0, 0, 1, 2'b10);
    cmp("R3", result, '0); check_ref();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule